// File: doc/BRIEF.md
# Multi-Latency Register-Stage Hazard Interlock

This block holds the dependency-checking logic for the register stage of a single-issue, in-order pipeline. Results come from pipelined functional units of different latency: two integer units (one execute cycle), one floating-point unit (four execute cycles) and two memory pipelines (two execute cycles). Each execute stage and each write-back stage of every unit reports a valid bit and the id of the register it will write.

The block compares the register-stage instruction's two source ids and its destination id against those stage destinations. It raises a stall when a source needs a value that is not yet produced, or when the new destination could be overwritten out of order by an older, slower write. When a source matches a value that already exists, the block names the stage that should drive that operand through the bypass network. Only the comparators and the priority logic are here. The functional units, the register file and the operand multiplexers are outside the block.

The block is purely combinational. The clock and reset inputs serve only the embedded property checks.

Top module: `hz_interlock`

## Requirements
- R1: A stage entry whose valid bit is low never matches, and register id 0 never matches in any comparison, whether as a source or as a destination.
- R2: A source id that matches an execute stage before the last one of its unit raises `stall`. Those stages are memory E1 and floating-point E1 to E3.
- R3: The destination id raises `stall` when it matches floating-point E1 to E3 or memory E1. It never raises `stall` by matching an integer stage, floating-point E4, memory E2 or any write-back stage.
- R4: A source id that matches only final execute stages or write-back stages (integer EXE/WRB, memory E2/WRB, floating-point E4/WRB) produces a bypass with `byp_vld` high and does not stall.
- R5: The bypass select is encoded as follows. `byp_unit` is 0 for integer, 1 for memory and 2 for floating-point. `byp_lane` is the unit lane. `byp_wb` is 1 for a write-back stage and 0 for a final execute stage. When `byp_vld` is low, `byp_unit`, `byp_lane` and `byp_wb` are all zero.
- R6: When several bypassable stages match, the youngest one wins. Age is the number of cycles since the producer left the register stage: integer EXE 1, integer WRB 2, memory E2 2, memory WRB 3, floating-point E4 4, floating-point WRB 5. The lowest age is chosen.
- R7: Ties in age are broken first by unit, integer before memory before floating-point, then by lower lane.
- R8: The two sources are resolved independently. Each has its own bypass select.
- R9: `stall` is the OR of all R2 and R3 conditions. The bypass selects are still produced while `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the property checks |
| rst_n | input | 1 | Active-low reset that disables the property checks |
| src_id | input | 2x5 | Source register ids of the register-stage instruction |
| dst_id | input | 5 | Destination register id of the register-stage instruction |
| int_vld | input | 2x2 | Integer lanes, valid bit per stage (index 0 EXE, 1 WRB) |
| int_dst | input | 2x2x5 | Integer lanes, destination id per stage |
| mem_vld | input | 2x3 | Memory lanes, valid bit per stage (0 E1, 1 E2, 2 WRB) |
| mem_dst | input | 2x3x5 | Memory lanes, destination id per stage |
| fp_vld | input | 5 | Floating-point valid bit per stage (0..3 E1..E4, 4 WRB) |
| fp_dst | input | 5x5 | Floating-point destination id per stage |
| stall | output | 1 | Hold the register-stage instruction this cycle |
| byp_vld | output | 2 | Per source: an operand is supplied by bypass |
| byp_unit | output | 2x2 | Per source: supplying unit class |
| byp_lane | output | 2x1 | Per source: supplying lane |
| byp_wb | output | 2 | Per source: 1 for write-back stage, 0 for final execute stage |

## Verification
The properties sample the inputs at the rising clock edge and take them to be settled there. They make no assumption about whether the in-flight stage contents form a legal instruction stream, so they hold for any combination of ids and valid bits. The bench changes all inputs on the falling edge. It draws register ids from a small range so that multiple and tied matches happen often. It does not restrict the stage contents to sequences a real pipeline could produce, so the age and tie-break rules are exercised beyond what legal traffic would reach.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_MEM = 2'd1,
    UNIT_FP  = 2'd2
  } unit_e;
endpackage

// File: rtl/hz_stage_cmp.sv
// Id comparator bank: every requested id against every stage destination of one unit lane.
module hz_stage_cmp #(
  parameter int REG_W = 5,
  parameter int NSTG  = 2,
  parameter int NSRC  = 3
) (
  input  logic [NSRC-1:0][REG_W-1:0] id_i,
  input  logic [NSTG-1:0]            vld_i,
  input  logic [NSTG-1:0][REG_W-1:0] dst_i,
  output logic [NSRC-1:0][NSTG-1:0]  hit_o
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar t = 0; t < NSTG; t++) begin : g_stg
      // id 0 is the hard-wired zero register: it never creates a dependency
      assign hit_o[s][t] = vld_i[t] && (|id_i[s]) && (dst_i[t] == id_i[s]);
    end
  end
endmodule

// File: rtl/hz_byp_pick.sv
// Chooses the matching candidate with the smallest age; equal ages keep the lower index.
module hz_byp_pick #(
  parameter int NCAND = 10,
  parameter int DEP_W = 3,
  parameter int IDX_W = 4
) (
  input  logic [NCAND-1:0]            hit_i,
  input  logic [NCAND-1:0][DEP_W-1:0] dep_i,
  output logic                        found_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [DEP_W-1:0] best_dep;

  always_comb begin
    found_o  = 1'b0;
    idx_o    = '0;
    best_dep = '1;
    for (int k = 0; k < NCAND; k++) begin
      if (hit_i[k] && (!found_o || (dep_i[k] < best_dep))) begin
        found_o  = 1'b1;
        idx_o    = IDX_W'(k);
        best_dep = dep_i[k];
      end
    end
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int REG_W   = 5,
  parameter int NUM_INT = 2,
  parameter int NUM_MEM = 2,
  parameter int FP_LAT  = 4,
  parameter int MEM_LAT = 2,
  localparam int MAX_LANES = (NUM_INT > NUM_MEM) ? NUM_INT : NUM_MEM,
  localparam int LANE_W    = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0][REG_W-1:0]                  src_id,
  input  logic [REG_W-1:0]                       dst_id,
  input  logic [NUM_INT-1:0][1:0]                int_vld,
  input  logic [NUM_INT-1:0][1:0][REG_W-1:0]     int_dst,
  input  logic [NUM_MEM-1:0][MEM_LAT:0]          mem_vld,
  input  logic [NUM_MEM-1:0][MEM_LAT:0][REG_W-1:0] mem_dst,
  input  logic [FP_LAT:0]                        fp_vld,
  input  logic [FP_LAT:0][REG_W-1:0]             fp_dst,
  output logic                                   stall,
  output logic [1:0]                             byp_vld,
  output logic [1:0][1:0]                        byp_unit,
  output logic [1:0][LANE_W-1:0]                 byp_lane,
  output logic [1:0]                             byp_wb
);
  import hz_pkg::*;

  localparam int NCAND   = 2 * NUM_INT + 2 * NUM_MEM + 2;
  localparam int IDX_W   = $clog2(NCAND);
  localparam int MAX_LAT = (FP_LAT > MEM_LAT) ? FP_LAT : MEM_LAT;
  localparam int DEP_W   = $clog2(MAX_LAT + 2);
  localparam int MEM_BASE = 2 * NUM_INT;
  localparam int FP_BASE  = 2 * NUM_INT + 2 * NUM_MEM;

  // ids under test: [0] source 0, [1] source 1, [2] destination
  logic [2:0][REG_W-1:0] cmp_id;
  assign cmp_id = {dst_id, src_id};

  logic [NUM_INT-1:0][2:0][1:0]       int_hit;
  logic [NUM_MEM-1:0][2:0][MEM_LAT:0] mem_hit;
  logic [2:0][FP_LAT:0]               fp_hit;

  // ---------------- comparator banks, one per unit lane ----------------
  for (genvar i = 0; i < NUM_INT; i++) begin : g_int
    hz_stage_cmp #(.REG_W(REG_W), .NSTG(2), .NSRC(3)) u_cmp (
      .id_i  (cmp_id),
      .vld_i (int_vld[i]),
      .dst_i (int_dst[i]),
      .hit_o (int_hit[i])
    );
  end

  for (genvar j = 0; j < NUM_MEM; j++) begin : g_mem
    hz_stage_cmp #(.REG_W(REG_W), .NSTG(MEM_LAT + 1), .NSRC(3)) u_cmp (
      .id_i  (cmp_id),
      .vld_i (mem_vld[j]),
      .dst_i (mem_dst[j]),
      .hit_o (mem_hit[j])
    );
  end

  hz_stage_cmp #(.REG_W(REG_W), .NSTG(FP_LAT + 1), .NSRC(3)) u_fp_cmp (
    .id_i  (cmp_id),
    .vld_i (fp_vld),
    .dst_i (fp_dst),
    .hit_o (fp_hit)
  );

  // ---------------- interlock: early execute stages ----------------
  // A value in an execute stage before the last is not yet produced (RAW),
  // and a slower older write there may land after ours (WAW).
  logic [NUM_MEM-1:0] mem_raw_wait, mem_waw_wait;
  logic               fp_raw_wait, fp_waw_wait;

  for (genvar j = 0; j < NUM_MEM; j++) begin : g_mem_wait
    if (MEM_LAT > 1) begin : g_multi
      assign mem_raw_wait[j] = (|mem_hit[j][0][MEM_LAT-2:0]) | (|mem_hit[j][1][MEM_LAT-2:0]);
      assign mem_waw_wait[j] = |mem_hit[j][2][MEM_LAT-2:0];
    end else begin : g_single
      assign mem_raw_wait[j] = 1'b0;
      assign mem_waw_wait[j] = 1'b0;
    end
  end

  if (FP_LAT > 1) begin : g_fp_wait
    assign fp_raw_wait = (|fp_hit[0][FP_LAT-2:0]) | (|fp_hit[1][FP_LAT-2:0]);
    assign fp_waw_wait = |fp_hit[2][FP_LAT-2:0];
  end else begin : g_fp_nowait
    assign fp_raw_wait = 1'b0;
    assign fp_waw_wait = 1'b0;
  end

  logic raw_wait, waw_wait;
  assign raw_wait = (|mem_raw_wait) | fp_raw_wait;
  assign waw_wait = (|mem_waw_wait) | fp_waw_wait;
  assign stall    = raw_wait | waw_wait;

  // ---------------- bypass candidates, ordered int / mem / fp ----------------
  logic [1:0][NCAND-1:0]         cand_hit;
  logic [NCAND-1:0][DEP_W-1:0]   cand_dep;
  logic [NCAND-1:0][1:0]         cand_unit;
  logic [NCAND-1:0][LANE_W-1:0]  cand_lane;
  logic [NCAND-1:0]              cand_wb;

  for (genvar i = 0; i < NUM_INT; i++) begin : g_int_cand
    for (genvar w = 0; w < 2; w++) begin : g_stg
      assign cand_dep [2*i+w] = DEP_W'(1 + w);
      assign cand_unit[2*i+w] = UNIT_INT;
      assign cand_lane[2*i+w] = LANE_W'(i);
      assign cand_wb  [2*i+w] = 1'(w);
      for (genvar s = 0; s < 2; s++) begin : g_src
        assign cand_hit[s][2*i+w] = int_hit[i][s][w];
      end
    end
  end

  for (genvar j = 0; j < NUM_MEM; j++) begin : g_mem_cand
    for (genvar w = 0; w < 2; w++) begin : g_stg
      assign cand_dep [MEM_BASE+2*j+w] = DEP_W'(MEM_LAT + w);
      assign cand_unit[MEM_BASE+2*j+w] = UNIT_MEM;
      assign cand_lane[MEM_BASE+2*j+w] = LANE_W'(j);
      assign cand_wb  [MEM_BASE+2*j+w] = 1'(w);
      for (genvar s = 0; s < 2; s++) begin : g_src
        assign cand_hit[s][MEM_BASE+2*j+w] = mem_hit[j][s][MEM_LAT-1+w];
      end
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_fp_cand
    assign cand_dep [FP_BASE+w] = DEP_W'(FP_LAT + w);
    assign cand_unit[FP_BASE+w] = UNIT_FP;
    assign cand_lane[FP_BASE+w] = '0;
    assign cand_wb  [FP_BASE+w] = 1'(w);
    for (genvar s = 0; s < 2; s++) begin : g_src
      assign cand_hit[s][FP_BASE+w] = fp_hit[s][FP_LAT-1+w];
    end
  end

  // ---------------- per-source youngest-producer selection ----------------
  logic [1:0][IDX_W-1:0] pick_idx;

  for (genvar s = 0; s < 2; s++) begin : g_pick
    hz_byp_pick #(.NCAND(NCAND), .DEP_W(DEP_W), .IDX_W(IDX_W)) u_pick (
      .hit_i   (cand_hit[s]),
      .dep_i   (cand_dep),
      .found_o (byp_vld[s]),
      .idx_o   (pick_idx[s])
    );
    assign byp_unit[s] = byp_vld[s] ? cand_unit[pick_idx[s]] : 2'd0;
    assign byp_lane[s] = byp_vld[s] ? cand_lane[pick_idx[s]] : '0;
    assign byp_wb[s]   = byp_vld[s] ? cand_wb[pick_idx[s]]   : 1'b0;
  end

  // ---------------- properties ----------------
  AST_ZERO_SRC0_NO_BYP: assert property (@(posedge clk) disable iff (!rst_n)
    (src_id[0] == '0) |-> !byp_vld[0]);                                    // R1
  AST_ZERO_SRC1_NO_BYP: assert property (@(posedge clk) disable iff (!rst_n)
    (src_id[1] == '0) |-> !byp_vld[1]);                                    // R1
  AST_FP_EARLY_RAW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_vld[0] && (src_id[0] != '0) && (fp_dst[0] == src_id[0])) |-> stall); // R2
  AST_MEM_EARLY_WAW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld[0][0] && (dst_id != '0) && (mem_dst[0][0] == dst_id)) |-> stall); // R3
  AST_INT_ONLY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((fp_vld == '0) && (mem_vld == '0)) |-> !stall);                        // R4
  AST_IDLE_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_vld[0] |-> ((byp_unit[0] == 2'd0) && (byp_wb[0] == 1'b0)));        // R5
  AST_UNIT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    byp_vld[1] |-> (byp_unit[1] != 2'd3));                                  // R5
  AST_INT_EXE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_vld[0][0] && (src_id[0] != '0) && (int_dst[0][0] == src_id[0]))
      |-> (byp_vld[0] && (byp_unit[0] == 2'd0) && !byp_wb[0]));             // R6
endmodule

// File: tb/hz_interlock_tb.sv
module hz_interlock_tb_top;
  localparam int RW  = 5;
  localparam int NI  = 2;
  localparam int NM  = 2;
  localparam int FL  = 4;
  localparam int ML  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0][RW-1:0]         src_id;
  logic [RW-1:0]              dst_id;
  logic [NI-1:0][1:0]         int_vld;
  logic [NI-1:0][1:0][RW-1:0] int_dst;
  logic [NM-1:0][ML:0]        mem_vld;
  logic [NM-1:0][ML:0][RW-1:0] mem_dst;
  logic [FL:0]                fp_vld;
  logic [FL:0][RW-1:0]        fp_dst;
  logic                       stall;
  logic [1:0]                 byp_vld;
  logic [1:0][1:0]            byp_unit;
  logic [1:0][0:0]            byp_lane;
  logic [1:0]                 byp_wb;

  hz_interlock dut_i (
    .clk(clk), .rst_n(rst_n), .src_id(src_id), .dst_id(dst_id),
    .int_vld(int_vld), .int_dst(int_dst), .mem_vld(mem_vld), .mem_dst(mem_dst),
    .fp_vld(fp_vld), .fp_dst(fp_dst), .stall(stall), .byp_vld(byp_vld),
    .byp_unit(byp_unit), .byp_lane(byp_lane), .byp_wb(byp_wb)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // ---------- behavioural reference: walk every in-flight result ----------
  function automatic int lat_of(int u);
    return (u == 0) ? 1 : (u == 1) ? ML : FL;
  endfunction
  function automatic int lanes_of(int u);
    return (u == 0) ? NI : (u == 1) ? NM : 1;
  endfunction
  function automatic bit vld_at(int u, int l, int st);
    if (u == 0) return int_vld[l][st];
    if (u == 1) return mem_vld[l][st];
    return fp_vld[st];
  endfunction
  function automatic int dst_at(int u, int l, int st);
    if (u == 0) return int'(int_dst[l][st]);
    if (u == 1) return int'(mem_dst[l][st]);
    return int'(fp_dst[st]);
  endfunction

  bit      e_stall;
  bit      e_vld  [2];
  int      e_unit [2];
  int      e_lane [2];
  int      e_wb   [2];

  task automatic model();
    int best_age [2];
    int best_key [2];
    e_stall = 1'b0;
    for (int s = 0; s < 2; s++) begin
      e_vld[s] = 1'b0; e_unit[s] = 0; e_lane[s] = 0; e_wb[s] = 0;
      best_age[s] = 1000; best_key[s] = 1000;
    end
    for (int u = 0; u < 3; u++)
      for (int l = 0; l < lanes_of(u); l++)
        for (int st = 0; st <= lat_of(u); st++) begin
          int age = st + 1;
          bit produced = (st >= lat_of(u) - 1);
          if (vld_at(u, l, st)) begin
            // WAW: only slower units, execute stages before the last
            if (u != 0 && !produced && dst_id != 0 && dst_at(u, l, st) == int'(dst_id))
              e_stall = 1'b1;
            for (int s = 0; s < 2; s++) begin
              if (src_id[s] != 0 && dst_at(u, l, st) == int'(src_id[s])) begin
                if (!produced) e_stall = 1'b1;
                else if (age < best_age[s] ||
                         (age == best_age[s] && (u * 16 + l) < best_key[s])) begin
                  best_age[s] = age; best_key[s] = u * 16 + l;
                  e_vld[s] = 1'b1; e_unit[s] = u; e_lane[s] = l;
                  e_wb[s] = (st == lat_of(u)) ? 1 : 0;
                end
              end
            end
          end
        end
  endtask

  task automatic chk(input string req);
    model();
    n_chk++;
    if (stall !== e_stall) begin
      n_fail++;
      $display("FAIL %s stall act=%0b exp=%0b", req, stall, e_stall);
    end
    for (int s = 0; s < 2; s++) begin
      n_chk++;
      if (byp_vld[s] !== e_vld[s] || int'(byp_unit[s]) != e_unit[s] ||
          int'(byp_lane[s]) != e_lane[s] || int'(byp_wb[s]) != e_wb[s]) begin
        n_fail++;
        $display("FAIL %s src%0d act=v%0b u%0d l%0d w%0d exp=v%0b u%0d l%0d w%0d",
                 req, s, byp_vld[s], byp_unit[s], byp_lane[s], byp_wb[s],
                 e_vld[s], e_unit[s], e_lane[s], e_wb[s]);
      end
    end
  endtask

  task automatic expect_stall(input string req, input bit exp);
    n_chk++;
    if (stall !== exp) begin
      n_fail++;
      $display("FAIL %s stall act=%0b exp=%0b", req, stall, exp);
    end
  endtask

  task automatic clear();
    src_id = '0; dst_id = '0; int_vld = '0; int_dst = '0;
    mem_vld = '0; mem_dst = '0; fp_vld = '0; fp_dst = '0;
  endtask

  task automatic settle();
    #2;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); settle(); chk("R1 idle");

    // R4: integer EXE bypass, no stall
    @(negedge clk); clear(); src_id[0] = 5'd5; int_vld[0][0] = 1'b1; int_dst[0][0] = 5'd5;
    settle(); chk("R4 int exe");
    // R1: invalid entry, and id zero
    @(negedge clk); int_vld[0][0] = 1'b0; settle(); chk("R1 invalid");
    @(negedge clk); clear(); int_vld[1][1] = 1'b1; fp_vld[0] = 1'b1; settle(); chk("R1 zero id");
    expect_stall("R1 zero id", 1'b0);
    // R2: memory E1 and FP E3 unready
    @(negedge clk); clear(); src_id[1] = 5'd7; mem_vld[1][0] = 1'b1; mem_dst[1][0] = 5'd7;
    settle(); chk("R2 mem e1"); expect_stall("R2 mem e1", 1'b1);
    @(negedge clk); clear(); src_id[0] = 5'd3; fp_vld[2] = 1'b1; fp_dst[2] = 5'd3;
    settle(); chk("R2 fp e3"); expect_stall("R2 fp e3", 1'b1);
    // R4/R5: FP E4 is bypassable, unit code 2, wb 0
    @(negedge clk); fp_vld = '0; fp_vld[3] = 1'b1; fp_dst[3] = 5'd3; settle(); chk("R5 fp e4");
    expect_stall("R4 fp e4", 1'b0);
    // R3: WAW checks
    @(negedge clk); clear(); dst_id = 5'd9; fp_vld[2] = 1'b1; fp_dst[2] = 5'd9;
    settle(); expect_stall("R3 fp e3 waw", 1'b1);
    @(negedge clk); fp_vld = '0; fp_vld[3] = 1'b1; fp_dst[3] = 5'd9; settle();
    expect_stall("R3 fp e4 no waw", 1'b0);
    @(negedge clk); fp_vld = '0; int_vld[0][0] = 1'b1; int_dst[0][0] = 5'd9; settle();
    expect_stall("R3 int no waw", 1'b0);
    @(negedge clk); int_vld = '0; mem_vld[0][0] = 1'b1; mem_dst[0][0] = 5'd9; settle();
    expect_stall("R3 mem e1 waw", 1'b1);
    @(negedge clk); mem_vld = '0; mem_vld[1][1] = 1'b1; mem_dst[1][1] = 5'd9; settle();
    expect_stall("R3 mem e2 no waw", 1'b0);
    // R6: youngest of int WRB, mem WRB, fp WRB
    @(negedge clk); clear(); src_id[0] = 5'd4;
    int_vld[1][1] = 1'b1; int_dst[1][1] = 5'd4;
    mem_vld[0][2] = 1'b1; mem_dst[0][2] = 5'd4;
    fp_vld[4] = 1'b1; fp_dst[4] = 5'd4;
    settle(); chk("R6 youngest");
    @(negedge clk); int_vld = '0; settle(); chk("R6 mem wrb");
    // R7: equal age, int WRB beats mem E2; lane 0 beats lane 1
    @(negedge clk); clear(); src_id[0] = 5'd4;
    mem_vld[0][1] = 1'b1; mem_dst[0][1] = 5'd4;
    int_vld[1][1] = 1'b1; int_dst[1][1] = 5'd4;
    settle(); chk("R7 tie unit");
    @(negedge clk); clear(); src_id[1] = 5'd6;
    mem_vld[1][2] = 1'b1; mem_dst[1][2] = 5'd6;
    mem_vld[0][2] = 1'b1; mem_dst[0][2] = 5'd6;
    settle(); chk("R7 tie lane");
    // R8: two sources from different units
    @(negedge clk); clear(); src_id[0] = 5'd1; src_id[1] = 5'd2;
    int_vld[1][0] = 1'b1; int_dst[1][0] = 5'd1; fp_vld[4] = 1'b1; fp_dst[4] = 5'd2;
    settle(); chk("R8 independent");
    // R9: stall with a live bypass on the other source
    @(negedge clk); clear(); src_id[0] = 5'd1; src_id[1] = 5'd2;
    int_vld[0][0] = 1'b1; int_dst[0][0] = 5'd1; fp_vld[0] = 1'b1; fp_dst[0] = 5'd2;
    settle(); chk("R9 stall+byp"); expect_stall("R9 stall+byp", 1'b1);

    // random mix with a small id range for frequent multiple matches
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      for (int s = 0; s < 2; s++) src_id[s] = RW'($urandom_range(0, 3));
      dst_id  = RW'($urandom_range(0, 3));
      int_vld = NI*2'($urandom); mem_vld = (NM*(ML+1))'($urandom); fp_vld = (FL+1)'($urandom);
      for (int l = 0; l < NI; l++) for (int st = 0; st < 2; st++) int_dst[l][st] = RW'($urandom_range(0, 3));
      for (int l = 0; l < NM; l++) for (int st = 0; st <= ML; st++) mem_dst[l][st] = RW'($urandom_range(0, 3));
      for (int st = 0; st <= FL; st++) fp_dst[st] = RW'($urandom_range(0, 3));
      settle();
      chk("R6 R7 R9 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule